// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic and logic unit assembled from a row of identical one-bit slices. Each slice can invert either of its operands, forms their AND, OR and full-adder sum, and picks one of these or an external "less" input as its result bit. A ripple carry links the slices. A 4-bit operation code steers the slice controls, so the same row computes AND, OR, NOR, NAND, addition, subtraction and a signed set-less-than.

Subtraction inverts the second operand and injects a carry of one into the lowest slice. Set-less-than performs the same subtraction. It corrects the top slice's sum sign with the signed overflow, and feeds that true sign back into the least significant slice through its "less" input. All higher slices receive zero on that input. Alongside the result the block reports a zero flag, a signed overflow flag and an unsigned overflow/borrow flag, so that a surrounding datapath can choose which overflow rule applies.

Top module: `slice_alu`

## Requirements
- R1: Code 0000 gives the bitwise AND of a and b; code 0001 gives the bitwise OR.
- R2: Code 1100 gives the bitwise NOR of a and b; code 1101 gives the bitwise NAND.
- R3: Code 0010 gives a + b modulo 2^32.
- R4: Code 0110 gives a - b modulo 2^32.
- R5: Code 0111 gives bit 0 equal to 1 exactly when a < b as signed two's complement numbers, with bit 31 the sign. This holds even when a - b overflows. Bits 31..1 are 0.
- R6: zero_o is 1 exactly when all 32 result bits are 0.
- R7: ovf_o reports signed overflow. For code 0010 it is 1 when a and b share a sign and the sum's sign differs from it. For codes 0110 and 0111 it is 1 when a and b differ in sign and the sign of a - b differs from the sign of a. For all other codes it is 0.
- R8: carry_o reports unsigned overflow. For code 0010 it is 1 when ~a, taken as unsigned, is less than b. For codes 0110 and 0111 it is 1 when a < b unsigned (a borrow). For all other codes it is 0.
- R9: Any code not listed above gives a result of 0, with ovf_o and carry_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow |
| carry_o | output | 1 | Unsigned overflow or borrow |

## Verification
The block holds no state, so a fault in a slice control, in the carry chain or in the less feedback is visible on result_o and the flags in the same evaluation as the stimulus. A broken carry link shows up only for operand pairs whose carries reach that slice. For that reason, random operands are mixed with sign-boundary and all-ones corners. The less-than path is exercised at operand pairs where a - b overflows, because in that region the raw sum sign gives the wrong answer.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_NOR  = 4'b1100,
    OP_NAND = 4'b1101
  } alu_op_e;

  // slice output select
  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } slice_sel_e;

  typedef struct packed {
    logic       valid;
    logic       arith;
    logic       a_inv;
    logic       b_inv;
    slice_sel_e sel;
  } slice_ctrl_t;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import slice_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       a_inv_i,
  input  logic       b_inv_i,
  input  logic       carry_i,
  input  logic       less_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       sum_o,
  output logic       carry_o
);
  logic a_eff, b_eff;

  assign a_eff   = a_i ^ a_inv_i;
  assign b_eff   = b_i ^ b_inv_i;
  assign sum_o   = a_eff ^ b_eff ^ carry_i;
  assign carry_o = (a_eff & b_eff) | (carry_i & (a_eff ^ b_eff));

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_eff & b_eff;
      SEL_OR:   res_o = a_eff | b_eff;
      SEL_SUM:  res_o = sum_o;
      default:  res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import slice_alu_pkg::*;
(
  input  logic [3:0]  op_i,
  output slice_ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o = '{valid: 1'b1, arith: 1'b0, a_inv: 1'b0, b_inv: 1'b0, sel: SEL_AND};
    case (op_i)
      OP_AND:  ctrl_o.sel = SEL_AND;
      OP_OR:   ctrl_o.sel = SEL_OR;
      OP_ADD:  begin ctrl_o.sel = SEL_SUM;  ctrl_o.arith = 1'b1; end
      OP_SUB:  begin ctrl_o.sel = SEL_SUM;  ctrl_o.arith = 1'b1; ctrl_o.b_inv = 1'b1; end
      OP_SLT:  begin ctrl_o.sel = SEL_LESS; ctrl_o.arith = 1'b1; ctrl_o.b_inv = 1'b1; end
      // De Morgan: ~a & ~b = NOR, ~a | ~b = NAND
      OP_NOR:  begin ctrl_o.sel = SEL_AND;  ctrl_o.a_inv = 1'b1; ctrl_o.b_inv = 1'b1; end
      OP_NAND: begin ctrl_o.sel = SEL_OR;   ctrl_o.a_inv = 1'b1; ctrl_o.b_inv = 1'b1; end
      default: ctrl_o.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             carry_o
);
  localparam int unsigned MSB = WIDTH - 1;

  slice_ctrl_t      ctrl;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] res;
  logic [WIDTH-1:0] less;
  logic             a_top, b_top, ovf_raw, set_lt;

  alu_op_decode i_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  // subtract: +1 into the chain together with the inverted b
  assign carry[0] = ctrl.b_inv & ctrl.arith;

  // signed overflow on the effective operands seen by the adder
  assign a_top   = a_i[MSB] ^ ctrl.a_inv;
  assign b_top   = b_i[MSB] ^ ctrl.b_inv;
  assign ovf_raw = (a_top ~^ b_top) & (sum[MSB] ^ a_top);
  // true sign of a - b, immune to overflow
  assign set_lt  = sum[MSB] ^ ovf_raw;

  assign less = {{(WIDTH-1){1'b0}}, set_lt};

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice i_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .a_inv_i (ctrl.a_inv),
      .b_inv_i (ctrl.b_inv),
      .carry_i (carry[i]),
      .less_i  (less[i]),
      .sel_i   (ctrl.sel),
      .res_o   (res[i]),
      .sum_o   (sum[i]),
      .carry_o (carry[i+1])
    );
  end

  assign result_o = ctrl.valid ? res : '0;
  assign zero_o   = ~|result_o;
  assign ovf_o    = ctrl.valid & ctrl.arith & ovf_raw;
  // add: carry out; subtract: borrow is the missing carry
  assign carry_o  = ctrl.valid & ctrl.arith & (carry[WIDTH] ^ ctrl.b_inv);
endmodule

// File: rtl/slice_alu_checker.sv
module slice_alu_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] result_o,
  input logic             ovf_o,
  input logic             carry_o
);
  localparam int unsigned MSB = WIDTH - 1;

  always_comb begin
    if (op_i == 4'b0010) begin
      a_r3_add_sum: assert (result_o == a_i + b_i);
      a_r7_add_ovf: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])));
      a_r8_add_carry: assert (carry_o == ((~a_i) < b_i));
    end
    if (op_i == 4'b0111) begin
      a_r5_slt_upper_zero: assert (result_o[MSB:1] == '0);
      a_r5_slt_signed: assert (result_o[0] == ($signed(a_i) < $signed(b_i)));
      a_r8_slt_borrow: assert (carry_o == (a_i < b_i));
    end
    if (op_i == 4'b0000 || op_i == 4'b0001 || op_i == 4'b1100 || op_i == 4'b1101) begin
      a_r7_logic_no_flags: assert (!ovf_o && !carry_o);
    end
  end
endmodule

bind slice_alu slice_alu_checker #(.WIDTH(WIDTH)) i_checker (
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .ovf_o    (ovf_o),
  .carry_o  (carry_o)
);

// File: tb/test_slice_alu.sv
module test_slice_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [31:0] result;
  logic        zero, ovf, carry;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  slice_alu i_slice_alu (
    .op_i(op), .a_i(a), .b_i(b),
    .result_o(result), .zero_o(zero), .ovf_o(ovf), .carry_o(carry)
  );

  function automatic logic [31:0] exp_res(logic [3:0] o, logic [31:0] x, logic [31:0] y);
    case (o)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return {31'd0, $signed(x) < $signed(y)};
      4'b1100: return ~(x | y);
      4'b1101: return ~(x & y);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_ovf(logic [3:0] o, logic [31:0] x, logic [31:0] y);
    logic [31:0] s = x + y;
    logic [31:0] d = x - y;
    case (o)
      4'b0010:         return (x[31] == y[31]) && (s[31] != x[31]);
      4'b0110, 4'b0111: return (x[31] != y[31]) && (d[31] != x[31]);
      default:         return 1'b0;
    endcase
  endfunction

  function automatic logic exp_carry(logic [3:0] o, logic [31:0] x, logic [31:0] y);
    case (o)
      4'b0010:          return (~x) < y;
      4'b0110, 4'b0111: return x < y;
      default:          return 1'b0;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] o);
    case (o)
      4'b0000, 4'b0001: return "R1";
      4'b1100, 4'b1101: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%b a=%h b=%h actual=%h expected=%h", req, what, op, a, b, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] o, logic [31:0] x, logic [31:0] y);
    logic [31:0] r;
    @(negedge clk);
    op = o; a = x; b = y;
    @(posedge clk);
    #1;
    r = exp_res(o, x, y);
    check(req_of(o), "result", result, r);
    check("R6", "zero", {31'd0, zero}, {31'd0, r == 32'd0});
    check("R7", "ovf", {31'd0, ovf}, {31'd0, exp_ovf(o, x, y)});
    check("R8", "carry", {31'd0, carry}, {31'd0, exp_carry(o, x, y)});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] codes [8] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100, 4'b1101, 4'b1010};
    logic [31:0] corners [6] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1, 32'h5555_AAAA};
    void'($urandom(32'd1234));
    op = 4'b0000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    // idle state: AND of zeros
    check("R6", "idle zero", {31'd0, zero}, 32'd1);
    check("R1", "idle result", result, 32'd0);
    // directed corners: every code over every corner pair
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(codes[k], corners[i], corners[j]);
    // R5: overflowing subtraction, raw sign would be wrong
    apply(4'b0111, 32'h8000_0000, 32'h0000_0001);
    apply(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    // R9: undefined codes
    for (int c = 0; c < 16; c++) apply(4'(c), 32'hDEAD_BEEF, 32'h1234_5678);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] x = $urandom;
      logic [31:0] y = $urandom;
      if (n % 5 == 0) y = x;
      if (n % 7 == 0) y = ~x + 32'd1;
      apply(codes[$urandom % 8], x, y);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule